// File: doc/BRIEF.md
# Per-bit policy register bank

This block is a bank of control and status registers placed on a simple memory-mapped port. Every register has its own per-bit policy, fixed by parameters: a reset value and masks for read-only bits, write-one-to-clear bits, clear-on-read bits, reserved bits and unimplemented bits. A bus master presents an address, write data, an access size in bytes and a read or write strobe. Read data comes back combinationally in the same cycle. Register updates take effect at the next clock edge.

Both directions are gated by one byte-enable window. Its width is the smaller of the access size and the register width. A narrow access therefore touches only the low bytes of a register. The register contents are also driven out in parallel, so that the surrounding logic can use the control fields. Two one-cycle diagnostic pulses report writes that try to alter reserved bits or that set unimplemented bits.

Register width is a parameter: 8, 16, 32 or 64 bits. Slot `i` lives at byte address `i * (REG_W/8)`. A per-slot map mask can leave holes in the address space.

Top module: `regbank`

## Requirements
- R1: After reset, each register holds its own configured reset value. This is visible on `regs_o` (slot 0 in the lowest `REG_W` bits) and on full-width reads.
- R2: A write to a mapped register gives the new value to each bit that is not read-only, not write-one-to-clear, not reserved and inside the enable window. Every other bit keeps its old value. A cycle with neither strobe changes no register.
- R3: After that merge, a write clears every bit that is set both in the write data and in the write-one-to-clear mask. A zero written to such a bit leaves it unchanged, and a write can never set such a bit.
- R4: The enable window covers the low `8*min(size_i, REG_W/8)` bits. `size_i = 0` gives an empty window. Bytes outside the window keep their value on a write.
- R5: A read of a mapped register returns the stored value ANDed with the enable window. All bits above the window read as zero.
- R6: A read clears each bit that lies both in the clear-on-read mask and in the enable window. The data returned in that cycle is the value before the clear.
- R7: An address is mapped only when it is a multiple of `REG_W/8`, its slot index is below `NUM_REGS`, and that slot's bit in `MAP_MASK` is 1. A write to any other address changes nothing, and a read from it returns zero.
- R8: A write to a mapped register where `(old value XOR write data) AND reserved mask` is nonzero raises `rsvd_err_o` for exactly the following cycle. The reserved bits still keep their old value.
- R9: A write to a mapped register whose data has any bit set in the unimplemented mask raises `unimp_err_o` for exactly the following cycle.
- R10: When read and write strobes are both active for one register, the stored result is that of the write, with no clear-on-read. The read data is the value held before that cycle.
- R11: Read-only and reserved bits never differ from their reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | REG_W | Write data |
| size_i | input | SIZE_W | Access size in bytes |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | REG_W | Read data, same cycle, zero when not reading a mapped register |
| rsvd_err_o | output | 1 | One-cycle pulse: a write tried to change reserved bits |
| unimp_err_o | output | 1 | One-cycle pulse: a write set unimplemented bits |
| regs_o | output | NUM_REGS*REG_W | Parallel view of all register contents |

## Verification
The hardest situation to reach is a cycle where a read and a write hit a clear-on-read register together. Only a single address bus exists, so the bench asserts both strobes on one address. It then expects pre-cycle read data and a stored value equal to the pure write result. The write-one-to-clear bits can only be observed at 1 because of their reset values, so those values set them. The bench clears the bits in stages, mixing narrow and full writes. Each stage checks that zeros leave the bits alone and that data in bytes outside the window still clears them.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  typedef struct packed {
    logic rsvd;
    logic unimp;
  } diag_t;

  // low nbytes bytes set, up to 8 bytes
  function automatic logic [63:0] byte_window(input int unsigned nbytes);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b < nbytes) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction
endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
module regbank_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int BYTES    = 4,
  parameter logic [NUM_REGS-1:0] MAP_MASK = '1,
  localparam int LOG_B  = $clog2(BYTES),
  localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [ADDR_W-1:0] idx_full;
  logic              aligned;
  logic              in_range;

  assign idx_full = addr_i >> LOG_B;

  generate
    if (LOG_B == 0) begin : g_byte
      assign aligned = 1'b1;
    end else begin : g_wide
      assign aligned = (addr_i[LOG_B-1:0] == '0);
    end
  endgenerate

  assign in_range = (idx_full < ADDR_W'(NUM_REGS));
  assign slot_o   = idx_full[SLOT_W-1:0];
  assign hit_o    = aligned && in_range && MAP_MASK[slot_o];
endmodule

// File: rtl/regbank_cell.sv
`timescale 1ns/1ps
module regbank_cell #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] RST_VAL  = '0,
  parameter logic [REG_W-1:0] RO_MSK   = '0,
  parameter logic [REG_W-1:0] W1C_MSK  = '0,
  parameter logic [REG_W-1:0] COR_MSK  = '0,
  parameter logic [REG_W-1:0] RSVD_MSK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] en_i,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] FIXED = RO_MSK | W1C_MSK | RSVD_MSK;

  logic [REG_W-1:0] q_q, q_d, keep;

  assign keep = FIXED | ~en_i;

  always_comb begin
    q_d = q_q;
    if (wr_i) begin
      // write wins over a same-cycle read
      q_d = (wdata_i & ~keep) | (q_q & keep);
      q_d = q_d & ~(wdata_i & W1C_MSK);
    end else if (rd_i) begin
      q_d = q_q & ~(COR_MSK & en_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/regbank_diag.sv
`timescale 1ns/1ps
module regbank_diag #(
  parameter int REG_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_hit_i,
  input  logic [REG_W-1:0]   old_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [REG_W-1:0]   rsvd_msk_i,
  input  logic [REG_W-1:0]   unimp_msk_i,
  output regbank_pkg::diag_t flags_o
);
  regbank_pkg::diag_t d_d, d_q;

  always_comb begin
    d_d.rsvd  = wr_hit_i && (((old_i ^ wdata_i) & rsvd_msk_i) != '0);
    d_d.unimp = wr_hit_i && ((wdata_i & unimp_msk_i) != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_d;
  end

  assign flags_o = d_q;
endmodule

// File: rtl/regbank.sv
`timescale 1ns/1ps
module regbank #(
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter int SIZE_W   = 4,
  parameter logic [NUM_REGS-1:0]       MAP_MASK   = 4'b1011,
  parameter logic [NUM_REGS*REG_W-1:0] RST_VALS   = 128'h123400FF_00000000_0000FFFF_5A0000A5,
  parameter logic [NUM_REGS*REG_W-1:0] RO_MSKS    = 128'h00000000_00000000_00000000_FF000000,
  parameter logic [NUM_REGS*REG_W-1:0] W1C_MSKS   = 128'h00000000_00000000_0000FFFF_00000000,
  parameter logic [NUM_REGS*REG_W-1:0] COR_MSKS   = 128'h000000FF_00000000_00000000_00000000,
  parameter logic [NUM_REGS*REG_W-1:0] RSVD_MSKS  = 128'h00000000_00000000_00000000_00F00000,
  parameter logic [NUM_REGS*REG_W-1:0] UNIMP_MSKS = 128'h00000000_00000000_00000000_000F0000,
  localparam int BYTES  = REG_W / 8,
  localparam int SLOT_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  input  logic [SIZE_W-1:0]         size_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic                      rsvd_err_o,
  output logic                      unimp_err_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  import regbank_pkg::*;

  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [SIZE_W-1:0] nbytes;
  logic [63:0]       win_full;
  logic [REG_W-1:0]  en_mask;
  logic [REG_W-1:0]  q_arr     [NUM_REGS];
  logic [REG_W-1:0]  rsvd_arr  [NUM_REGS];
  logic [REG_W-1:0]  unimp_arr [NUM_REGS];
  logic [REG_W-1:0]  cur_q, cur_rsvd, cur_unimp;
  diag_t             flags;

  regbank_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BYTES(BYTES), .MAP_MASK(MAP_MASK)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .slot_o(slot)
  );

  assign nbytes   = (size_i > SIZE_W'(BYTES)) ? SIZE_W'(BYTES) : size_i;
  assign win_full = byte_window(32'(nbytes));
  assign en_mask  = win_full[REG_W-1:0];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      regbank_cell #(
        .REG_W   (REG_W),
        .RST_VAL (RST_VALS [i*REG_W +: REG_W]),
        .RO_MSK  (RO_MSKS  [i*REG_W +: REG_W]),
        .W1C_MSK (W1C_MSKS [i*REG_W +: REG_W]),
        .COR_MSK (COR_MSKS [i*REG_W +: REG_W]),
        .RSVD_MSK(RSVD_MSKS[i*REG_W +: REG_W])
      ) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_i && hit && (slot == SLOT_W'(i))),
        .rd_i   (rd_i && hit && (slot == SLOT_W'(i))),
        .wdata_i(wdata_i),
        .en_i   (en_mask),
        .q_o    (q_arr[i])
      );
      assign rsvd_arr[i]  = RSVD_MSKS [i*REG_W +: REG_W];
      assign unimp_arr[i] = UNIMP_MSKS[i*REG_W +: REG_W];
      assign regs_o[i*REG_W +: REG_W] = q_arr[i];
    end
  endgenerate

  assign cur_q     = q_arr[slot];
  assign cur_rsvd  = rsvd_arr[slot];
  assign cur_unimp = unimp_arr[slot];

  assign rdata_o = (rd_i && hit) ? (cur_q & en_mask) : '0;

  regbank_diag #(.REG_W(REG_W)) u_diag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hit_i   (wr_i && hit),
    .old_i      (cur_q),
    .wdata_i    (wdata_i),
    .rsvd_msk_i (cur_rsvd),
    .unimp_msk_i(cur_unimp),
    .flags_o    (flags)
  );

  assign rsvd_err_o  = flags.rsvd;
  assign unimp_err_o = flags.unimp;
endmodule

// File: rtl/regbank_chk.sv
`timescale 1ns/1ps
module regbank_chk #(
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter int SIZE_W   = 4,
  parameter logic [NUM_REGS-1:0]       MAP_MASK  = '1,
  parameter logic [NUM_REGS*REG_W-1:0] RST_VALS  = '0,
  parameter logic [NUM_REGS*REG_W-1:0] RO_MSKS   = '0,
  parameter logic [NUM_REGS*REG_W-1:0] W1C_MSKS  = '0,
  parameter logic [NUM_REGS*REG_W-1:0] RSVD_MSKS = '0
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [SIZE_W-1:0]         size_i,
  input logic                      wr_i,
  input logic                      rd_i,
  input logic [REG_W-1:0]          rdata_o,
  input logic                      rsvd_err_o,
  input logic                      unimp_err_o,
  input logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int BYTES = REG_W / 8;
  localparam logic [NUM_REGS*REG_W-1:0] FIX = RO_MSKS | RSVD_MSKS;

  logic             mapped;
  logic [REG_W-1:0] win;

  always_comb begin
    int a;
    int lim;
    a = int'(addr_i);
    mapped = 1'b0;
    if ((a % BYTES) == 0 && (a / BYTES) < NUM_REGS) mapped = MAP_MASK[a / BYTES];
    lim = (int'(size_i) < BYTES) ? int'(size_i) : BYTES;
    for (int b = 0; b < REG_W; b++) win[b] = (b < lim * 8);
  end

  assert_rdata_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~win) == '0);
  assert_unmapped_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |-> (rdata_o == '0));
  assert_fixed_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o & FIX) == (RST_VALS & FIX));
  assert_w1c_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((regs_o & W1C_MSKS & ~$past(regs_o)) == '0));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i) |=> $stable(regs_o));
  assert_rsvd_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_err_o |-> $past(wr_i));
  assert_unimp_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimp_err_o |-> $past(wr_i));
endmodule

bind regbank regbank_chk #(
  .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
  .MAP_MASK(MAP_MASK), .RST_VALS(RST_VALS), .RO_MSKS(RO_MSKS),
  .W1C_MSKS(W1C_MSKS), .RSVD_MSKS(RSVD_MSKS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .size_i(size_i),
  .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .rsvd_err_o(rsvd_err_o),
  .unimp_err_o(unimp_err_o), .regs_o(regs_o)
);

// File: tb/tb_regbank.sv
`timescale 1ns/1ps
module tb_regbank;
  localparam int N = 4;
  localparam logic [N-1:0] MAP = 4'b1011;
  localparam logic [127:0] RSTV  = 128'h123400FF_00000000_0000FFFF_5A0000A5;
  localparam logic [127:0] RO    = 128'h00000000_00000000_00000000_FF000000;
  localparam logic [127:0] W1C   = 128'h00000000_00000000_0000FFFF_00000000;
  localparam logic [127:0] COR   = 128'h000000FF_00000000_00000000_00000000;
  localparam logic [127:0] RSVD  = 128'h00000000_00000000_00000000_00F00000;
  localparam logic [127:0] UNIMP = 128'h00000000_00000000_00000000_000F0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [3:0]   size = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [31:0]  rdata;
  logic         rsvd_err, unimp_err;
  logic [127:0] regs;

  always #2.5 clk = ~clk;

  regbank #(
    .REG_W(32), .NUM_REGS(N), .ADDR_W(8), .SIZE_W(4), .MAP_MASK(MAP),
    .RST_VALS(RSTV), .RO_MSKS(RO), .W1C_MSKS(W1C), .COR_MSKS(COR),
    .RSVD_MSKS(RSVD), .UNIMP_MSKS(UNIMP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .rsvd_err_o(rsvd_err),
    .unimp_err_o(unimp_err), .regs_o(regs)
  );

  typedef struct {
    int           cyc;
    int           kind;   // 0 rdata, 1 rsvd flag, 2 unimp flag, 3 all registers
    logic [127:0] exp;
    string        tag;
  } item_t;

  item_t       sb[$];
  item_t       it;
  int          cyc = 0;
  int          total = 0, bad = 0;
  bit          done = 0;
  logic [31:0] m[N];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      logic [127:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = {96'b0, rdata};
        1:       act = {127'b0, rsvd_err};
        2:       act = {127'b0, unimp_err};
        default: act = regs;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] slice(input logic [127:0] v, input int s);
    return v[s*32 +: 32];
  endfunction

  task automatic push(input int c, input int k, input logic [127:0] e, input string t);
    item_t x;
    x.cyc = c; x.kind = k; x.exp = e; x.tag = t;
    sb.push_back(x);
  endtask

  // driver: one bus cycle, expectations from the requirements
  task automatic op(input bit w, input bit r, input int a, input int sz,
                    input logic [31:0] d, input string tag);
    int          c, s, nb;
    bit          hit;
    logic [31:0] en, old, nv, er;
    @(posedge clk);
    #1;
    wr = w; rd = r; addr = 8'(a); size = 4'(sz); wdata = d;
    c   = cyc;
    nb  = (sz < 4) ? sz : 4;
    en  = '0;
    for (int b = 0; b < 32; b++) if (b < nb * 8) en[b] = 1'b1;
    s   = a / 4;
    hit = (a % 4 == 0) && (s < N) && MAP[s % N];
    old = hit ? m[s] : '0;
    er  = (r && hit) ? (old & en) : '0;
    push(c, 0, {96'b0, er}, tag);
    push(c + 1, 1, {127'b0, w && hit && (((old ^ d) & slice(RSVD, s)) != 0)}, tag);
    push(c + 1, 2, {127'b0, w && hit && ((d & slice(UNIMP, s)) != 0)}, tag);
    if (hit) begin
      nv = old;
      for (int b = 0; b < 32; b++) begin
        if (w) begin
          if (!slice(RO, s)[b] && !slice(W1C, s)[b] && !slice(RSVD, s)[b] && en[b]) nv[b] = d[b];
          if (slice(W1C, s)[b] && d[b]) nv[b] = 1'b0;
        end else if (r) begin
          if (slice(COR, s)[b] && en[b]) nv[b] = 1'b0;
        end
      end
      m[s] = nv;
    end
    push(c + 1, 3, {m[3], m[2], m[1], m[0]}, tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m[i] = slice(RSTV, i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset image and full reads
    op(0, 0, 0, 4, 32'h0, "R1 idle after reset");
    op(0, 1, 0, 4, 32'h0, "R1 read reg0");
    op(0, 1, 4, 4, 32'h0, "R1 read reg1");
    // R2, R8, R9: full write of ones hits RO, reserved, unimplemented
    op(1, 0, 0, 4, 32'hFFFF_FFFF, "R2 R8 R9 all ones to reg0");
    op(1, 0, 0, 4, 32'h00F0_0000, "R8 reserved kept at one against stored zero");
    op(1, 0, 0, 4, 32'h0000_1234, "R2 plain write reg0");
    op(0, 1, 0, 4, 32'h0, "R2 readback reg0");
    // R4: narrow writes
    op(1, 0, 0, 1, 32'hABCD_EF77, "R4 byte write");
    op(1, 0, 0, 2, 32'hABCD_9988, "R4 half write");
    op(1, 0, 0, 0, 32'h0000_0000, "R4 zero size write");
    op(1, 0, 0, 8, 32'h0001_0042, "R4 R9 oversize clipped");
    // R5: narrow reads
    op(0, 1, 0, 1, 32'h0, "R5 byte read");
    op(0, 1, 0, 2, 32'h0, "R5 half read");
    op(0, 1, 0, 0, 32'h0, "R5 zero size read");
    // R3: write-one-to-clear
    op(1, 0, 4, 4, 32'h0000_000F, "R3 clear low nibble");
    op(1, 0, 4, 4, 32'hBEEF_0000, "R3 zeros keep w1c, upper writable");
    op(1, 0, 4, 1, 32'h0000_0F00, "R3 data outside window still clears");
    op(0, 1, 4, 4, 32'h0, "R3 readback reg1");
    // R6: clear on read
    op(0, 1, 12, 1, 32'h0, "R6 byte read of cor reg");
    op(0, 1, 12, 4, 32'h0, "R6 reread after clear");
    op(1, 0, 12, 4, 32'h0000_5A55, "R6 rewrite cor bits");
    op(0, 1, 12, 2, 32'h0, "R6 half read clears");
    // R10: read and write together
    op(1, 0, 12, 4, 32'h0000_00C3, "R10 preload");
    op(1, 1, 12, 4, 32'h7700_0081, "R10 write wins, old data read");
    op(0, 1, 12, 4, 32'h0, "R10 readback");
    // R7: unmapped addresses
    op(1, 0, 8, 4, 32'hFFFF_FFFF, "R7 write to hole");
    op(0, 1, 8, 4, 32'h0, "R7 read hole");
    op(1, 1, 2, 4, 32'hFFFF_FFFF, "R7 unaligned");
    op(1, 1, 16, 4, 32'hFFFF_FFFF, "R7 out of range");
    op(1, 1, 200, 4, 32'hFFFF_FFFF, "R7 far address");
    // R11: fixed bits after all traffic
    op(0, 1, 0, 4, 32'h0, "R11 reg0 fixed fields");
    op(0, 0, 0, 4, 32'h0, "R8 R9 pulses dropped");
    op(0, 0, 0, 4, 32'h0, "drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule